// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block sits between the pulse-width modulator of a synchronous buck controller and its two gate drivers. It turns a single "high side wanted" request into separate enables for the high-side and low-side switches. Neither switch may turn on until the other gate has been seen below its conduction threshold, so the dead time follows the real switching speed of the transistors rather than a fixed delay. A short minimum hold on that threshold flag filters comparator glitches. A watchdog ends the wait if a threshold flag never arrives, and it reports that event.

While start-up is in progress the low side runs as a simulated diode. It conducts after each high-side pulse, but a phase-below-ground flag switches it off for the remainder of that switching period, so inductor current never reverses into a pre-charged output. Once start-up ends the low side conducts for the full off-time. Fault logic can end the current high-side pulse early, clamp the output low through the low side, or float both drivers.

A switching period begins on each rising edge of the request. Both the early-termination latch and the diode cutoff latch are cleared at that point.

Top module: `gate_deadtime_ctl`

## Requirements
- R1: The low-side enable rises only after `hs_below_th` has been 1 for `MIN_DT` consecutive clocks while the high-side enable was 0, except on a watchdog release. With `MIN_DT`=3 and the flag already high, `ls_on` rises on the 4th clock edge after the low side becomes the wanted side.
- R2: The high-side enable rises only after `ls_below_th` has been 1 for `MIN_DT` consecutive clocks while the low-side enable was 0, except on a watchdog release. If the flag has already been high that long, `hs_on` rises on the first clock edge at which the high side is wanted.
- R3: `hs_on` and `ls_on` are never 1 together, and every handover between them passes through at least one clock with both at 0.
- R4: While `softstart_act`=1, `phase_neg`=1 with the low side on switches the low side off at the next edge. It stays off until the next rising edge of `pwm_req`.
- R5: `pulse_kill`=1 turns the high side off at the next edge. It stays off for the rest of the period, even with `pwm_req` still 1, until the next rising edge of `pwm_req`.
- R6: `force_low`=1 turns the high side off at the next edge and then drives the low side on through the normal dead-time wait, whatever the state of `pwm_req`.
- R7: `tristate_req`=1 clears both enables and sets `drv_hiz` at the next edge. It has priority over every other input.
- R8: While `softstart_act`=0, `phase_neg` has no effect: the low side stays on for the whole off-time.
- R9: If a wanted side has waited `WD_LIMIT` clocks without a qualified threshold flag, it turns on at the next edge. `wd_err` is 1 for exactly that one clock.
- R10: While `rst_n`=0, all four outputs are 0.
- R11: When the request for the side that is on goes away, that enable falls at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_req | input | 1 | 1 requests the high side; a rising edge starts a new period |
| hs_below_th | input | 1 | 1 when the high-side gate is below its turn-on threshold |
| ls_below_th | input | 1 | 1 when the low-side gate is below its turn-on threshold |
| phase_neg | input | 1 | 1 when the switch node is below ground |
| softstart_act | input | 1 | 1 while start-up is in progress (diode emulation) |
| pulse_kill | input | 1 | Ends the high-side pulse for the rest of the period |
| force_low | input | 1 | Holds the low side on and the high side off |
| tristate_req | input | 1 | Turns both drivers off and floats them |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |
| drv_hiz | output | 1 | Drivers floated |
| wd_err | output | 1 | One-clock pulse when a gate wait was ended by the watchdog |

## Verification
A dead-time counter stuck or cleared at the wrong time shows up as a gate enable that rises a clock early or late against the threshold flag. The bench pins this down by checking the exact edge of each turn-on. A diode-cutoff or kill latch that does not clear at the period boundary leaves a side dark through the next period, and the check one cycle after the next request rise catches it. A watchdog counter that fails to restart moves the forced turn-on and the `wd_err` pulse off their expected clock, which is checked exactly.

// File: rtl/gdt_pkg.sv
// Shared types for the adaptive dead-time gate sequencer.
package gdt_pkg;

    // Which switch the control inputs currently ask for.
    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_HIGH = 2'd1,
        SIDE_LOW  = 2'd2
    } side_e;

    // Conduction state of the half bridge.
    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_HS  = 2'd1,
        ST_LS  = 2'd2
    } bridge_st_e;

    // Index of each side in per-side arrays.
    localparam int SIDE_HS_IDX = 0;
    localparam int SIDE_LS_IDX = 1;
    localparam int SIDE_COUNT  = 2;

endpackage

// File: rtl/gdt_period_latch.sv
// Period-scoped latches.
// Detects the start of a switching period (rising pwm_req). It holds
// the early-termination request and the diode-emulation cutoff until
// that boundary.
// Assumes pwm_req is synchronous to clk.
module gdt_period_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_req,
    input  logic pulse_kill,
    input  logic softstart_act,
    input  logic phase_neg,
    input  logic ls_active,
    output logic kill_active,
    output logic de_block
);

    logic pwm_d;
    logic kill_q;
    logic de_q;
    logic period_start;
    logic de_trip;

    assign period_start = pwm_req & ~pwm_d;
    assign de_trip      = softstart_act & phase_neg & ls_active;

    // Kill takes effect in the same cycle it is raised and lasts to the period edge (R5).
    assign kill_active  = pulse_kill | (kill_q & ~period_start);
    // Diode cutoff only matters during start-up (R4, R8).
    assign de_block     = softstart_act & ((de_q & ~period_start) | de_trip);

    // Delayed copy of the request for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_d <= 1'b0;
        else        pwm_d <= pwm_req;
    end

    // Early-termination latch: set by a kill, cleared at the next period start.
    always_ff @(posedge clk) begin
        if (!rst_n)            kill_q <= 1'b0;
        else if (pulse_kill)   kill_q <= 1'b1;
        else if (period_start) kill_q <= 1'b0;
    end

    // Diode-emulation cutoff latch: set when phase goes negative with the low side on.
    always_ff @(posedge clk) begin
        if (!rst_n)                               de_q <= 1'b0;
        else if (period_start || !softstart_act)  de_q <= 1'b0;
        else if (de_trip)                         de_q <= 1'b1;
    end

endmodule

// File: rtl/gdt_side_select.sv
// Priority decode of the wanted side.
// Order: tristate, force-low, high-side request, diode cutoff, low side.
// Purely combinational.
module gdt_side_select
    import gdt_pkg::*;
(
    input  logic  pwm_req,
    input  logic  kill_active,
    input  logic  de_block,
    input  logic  force_low,
    input  logic  tristate_req,
    output side_e target
);

    // Choose the side the bridge should conduct on.
    always_comb begin
        if (tristate_req)                   target = SIDE_NONE;
        else if (force_low)                 target = SIDE_LOW;
        else if (pwm_req && !kill_active)   target = SIDE_HIGH;
        else if (de_block)                  target = SIDE_NONE;
        else                                target = SIDE_LOW;
    end

endmodule

// File: rtl/gdt_dead_timer.sv
// Turn-on qualifier for one side.
// Counts consecutive clocks in which the opposite gate is commanded off
// and reports itself below threshold. It grants turn-on once the count
// reaches MIN_DT. A watchdog grants turn-on anyway after WD_LIMIT clocks
// of waiting, and pulses wd_fire.
// Assumes MIN_DT >= 1 and WD_LIMIT >= 1.
module gdt_dead_timer #(
    parameter int MIN_DT   = 4,
    parameter int WD_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic opp_en,
    input  logic opp_below,
    input  logic want,
    output logic go,
    output logic wd_fire
);

    localparam int CNT_W = $clog2(MIN_DT + 1);
    localparam int WD_W  = $clog2(WD_LIMIT + 1);
    localparam logic [CNT_W-1:0] DT_MAX = CNT_W'(MIN_DT);
    localparam logic [WD_W-1:0]  WD_MAX = WD_W'(WD_LIMIT);

    logic [CNT_W-1:0] qual_q;
    logic [WD_W-1:0]  wait_q;
    logic             ready;

    assign ready   = (qual_q == DT_MAX);
    assign wd_fire = want & ~ready & (wait_q == WD_MAX);
    assign go      = want & (ready | wd_fire);

    // Qualification counter: the opposite flag must stay low-gate while that gate is commanded off.
    always_ff @(posedge clk) begin
        if (!rst_n)                   qual_q <= '0;
        else if (opp_en || !opp_below) qual_q <= '0;
        else if (qual_q != DT_MAX)    qual_q <= qual_q + 1'b1;
    end

    // Wait watchdog: counts clocks spent wanting this side without qualification.
    always_ff @(posedge clk) begin
        if (!rst_n)                wait_q <= '0;
        else if (!want || ready)   wait_q <= '0;
        else if (wait_q != WD_MAX) wait_q <= wait_q + 1'b1;
    end

endmodule

// File: rtl/gate_deadtime_ctl.sv
// Adaptive dead-time gate sequencer (top).
// Registers the bridge state (off / high / low). A side is left at the
// clock after its request ends. A side is entered only when its dead
// timer grants turn-on. Direct high-to-low moves do not exist: the bridge
// always passes through OFF.
// Assumes all inputs are synchronous to clk.
module gate_deadtime_ctl
    import gdt_pkg::*;
#(
    parameter int MIN_DT   = 4,
    parameter int WD_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_req,
    input  logic hs_below_th,
    input  logic ls_below_th,
    input  logic phase_neg,
    input  logic softstart_act,
    input  logic pulse_kill,
    input  logic force_low,
    input  logic tristate_req,
    output logic hs_on,
    output logic ls_on,
    output logic drv_hiz,
    output logic wd_err
);

    bridge_st_e state_q;
    bridge_st_e state_d;
    side_e      target;
    logic       kill_active;
    logic       de_block;
    logic       hiz_q;
    logic       err_q;

    logic [SIDE_COUNT-1:0] want;
    logic [SIDE_COUNT-1:0] go;
    logic [SIDE_COUNT-1:0] fire;
    logic [SIDE_COUNT-1:0] opp_en;
    logic [SIDE_COUNT-1:0] opp_below;

    assign hs_on   = (state_q == ST_HS);
    assign ls_on   = (state_q == ST_LS);
    assign drv_hiz = hiz_q;
    assign wd_err  = err_q;

    gdt_period_latch u_period (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwm_req       (pwm_req),
        .pulse_kill    (pulse_kill),
        .softstart_act (softstart_act),
        .phase_neg     (phase_neg),
        .ls_active     (ls_on),
        .kill_active   (kill_active),
        .de_block      (de_block)
    );

    gdt_side_select u_select (
        .pwm_req      (pwm_req),
        .kill_active  (kill_active),
        .de_block     (de_block),
        .force_low    (force_low),
        .tristate_req (tristate_req),
        .target       (target)
    );

    // Per-side wiring: each side watches the opposite gate.
    assign opp_en[SIDE_HS_IDX]    = ls_on;
    assign opp_below[SIDE_HS_IDX] = ls_below_th;
    assign want[SIDE_HS_IDX]      = (state_q == ST_OFF) && (target == SIDE_HIGH);
    assign opp_en[SIDE_LS_IDX]    = hs_on;
    assign opp_below[SIDE_LS_IDX] = hs_below_th;
    assign want[SIDE_LS_IDX]      = (state_q == ST_OFF) && (target == SIDE_LOW);

    for (genvar s = 0; s < SIDE_COUNT; s++) begin : g_side
        gdt_dead_timer #(
            .MIN_DT   (MIN_DT),
            .WD_LIMIT (WD_LIMIT)
        ) u_timer (
            .clk       (clk),
            .rst_n     (rst_n),
            .opp_en    (opp_en[s]),
            .opp_below (opp_below[s]),
            .want      (want[s]),
            .go        (go[s]),
            .wd_fire   (fire[s])
        );
    end

    // Next bridge state: drop a side as soon as it is unwanted, enter one only on grant.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HS:   if (target != SIDE_HIGH) state_d = ST_OFF;
            ST_LS:   if (target != SIDE_LOW)  state_d = ST_OFF;
            default: begin
                if (go[SIDE_HS_IDX])      state_d = ST_HS;
                else if (go[SIDE_LS_IDX]) state_d = ST_LS;
            end
        endcase
    end

    // Bridge state register (R10: reset to all-off).
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Float indicator follows the tristate request one clock later (R7).
    always_ff @(posedge clk) begin
        if (!rst_n) hiz_q <= 1'b0;
        else        hiz_q <= tristate_req;
    end

    // Watchdog error pulse, aligned with the forced turn-on (R9).
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= |fire;
    end

endmodule

// File: rtl/gdt_checker.sv
// Property checker for gate_deadtime_ctl, attached with bind.
// Observes ports only.
module gdt_checker (
    input logic clk,
    input logic rst_n,
    input logic pwm_req,
    input logic hs_below_th,
    input logic ls_below_th,
    input logic phase_neg,
    input logic softstart_act,
    input logic pulse_kill,
    input logic force_low,
    input logic tristate_req,
    input logic hs_on,
    input logic ls_on,
    input logic drv_hiz,
    input logic wd_err
);

    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on));

    a_r3_break_before_make: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_on) |-> !$past(ls_on)) and ($rose(ls_on) |-> !$past(hs_on)));

    a_r2_hs_waits_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_on) && !wd_err) |-> $past(ls_below_th, 2));

    a_r1_ls_waits_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ls_on) && !wd_err) |-> $past(hs_below_th, 2));

    a_r5_kill_ends_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_kill |=> !hs_on);

    a_r6_force_low_blocks_hs: assert property (@(posedge clk) disable iff (!rst_n)
        force_low |=> !hs_on);

    a_r7_tristate: assert property (@(posedge clk) disable iff (!rst_n)
        tristate_req |=> (!hs_on && !ls_on && drv_hiz));

    a_r4_diode_cutoff: assert property (@(posedge clk) disable iff (!rst_n)
        (softstart_act && phase_neg && ls_on && !force_low) |=> !ls_on);

    a_r8_ccm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_on && !softstart_act && !pwm_req && !tristate_req) |=> ls_on);

    a_r9_err_with_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
        wd_err |-> ($rose(hs_on) || $rose(ls_on)));

endmodule

bind gate_deadtime_ctl gdt_checker u_gdt_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwm_req       (pwm_req),
    .hs_below_th   (hs_below_th),
    .ls_below_th   (ls_below_th),
    .phase_neg     (phase_neg),
    .softstart_act (softstart_act),
    .pulse_kill    (pulse_kill),
    .force_low     (force_low),
    .tristate_req  (tristate_req),
    .hs_on         (hs_on),
    .ls_on         (ls_on),
    .drv_hiz       (drv_hiz),
    .wd_err        (wd_err)
);

// File: tb/gate_deadtime_ctl_test.sv
// Scoreboard bench: the driver pushes expected output items with a due
// cycle. The monitor pops them at the falling edge of that cycle and
// compares. Bench parameters: MIN_DT=3, WD_LIMIT=20.
module gate_deadtime_ctl_test;

    localparam int MIN_DT   = 3;
    localparam int WD_LIMIT = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_req = 1'b0;
    logic hs_below_th = 1'b1;
    logic ls_below_th = 1'b1;
    logic phase_neg = 1'b0;
    logic softstart_act = 1'b0;
    logic pulse_kill = 1'b0;
    logic force_low = 1'b0;
    logic tristate_req = 1'b0;
    logic hs_on, ls_on, drv_hiz, wd_err;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    due;
        logic  hs;
        logic  ls;
        logic  hiz;
        logic  err;
        string req;
    } exp_t;

    exp_t sb[$];

    gate_deadtime_ctl #(.MIN_DT(MIN_DT), .WD_LIMIT(WD_LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .pwm_req(pwm_req),
        .hs_below_th(hs_below_th), .ls_below_th(ls_below_th),
        .phase_neg(phase_neg), .softstart_act(softstart_act),
        .pulse_kill(pulse_kill), .force_low(force_low),
        .tristate_req(tristate_req),
        .hs_on(hs_on), .ls_on(ls_on), .drv_hiz(drv_hiz), .wd_err(wd_err)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Advance n clock edges; inputs change 1 ns after the edge.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Push an expectation due k cycles from now.
    task automatic exp_at(input int k, input logic hs, input logic ls,
                          input logic hiz, input logic err, input string req);
        exp_t e;
        e.due = cyc + k; e.hs = hs; e.ls = ls; e.hiz = hiz; e.err = err; e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: compare outputs at the falling edge of each due cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.due != cyc || {hs_on, ls_on, drv_hiz, wd_err} !== {e.hs, e.ls, e.hiz, e.err}) begin
                errors++;
                $display("FAIL %s cyc=%0d hs/ls/hiz/err actual %b%b%b%b expected %b%b%b%b",
                         e.req, cyc, hs_on, ls_on, drv_hiz, wd_err, e.hs, e.ls, e.hiz, e.err);
            end
        end
    end

    // Watchdog for a hung run.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired at cyc=%0d", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: outputs quiet in reset.
        tick(2);
        exp_at(1, 0, 0, 0, 0, "R10");
        exp_at(2, 0, 0, 0, 0, "R10");
        tick(2);
        rst_n = 1'b1;

        // R1: low side wanted after reset, waits MIN_DT clocks of hs flag.
        exp_at(1, 0, 0, 0, 0, "R1");
        exp_at(3, 0, 0, 0, 0, "R1");
        exp_at(4, 0, 1, 0, 0, "R1");
        tick(4);
        ls_below_th = 1'b0;

        // R2: high side waits for the slow low-side gate flag.
        pwm_req = 1'b1;
        exp_at(1, 0, 0, 0, 0, "R11");
        exp_at(3, 0, 0, 0, 0, "R2");
        exp_at(5, 0, 0, 0, 0, "R2");
        tick(5);
        ls_below_th = 1'b1;
        exp_at(3, 0, 0, 0, 0, "R2");
        exp_at(4, 1, 0, 0, 0, "R2");
        tick(4);
        hs_below_th = 1'b0;

        // R5: pulse kill ends high side for the rest of the period.
        pulse_kill = 1'b1;
        exp_at(1, 0, 0, 0, 0, "R5");
        tick(1);
        pulse_kill = 1'b0;
        hs_below_th = 1'b1;
        exp_at(2, 0, 0, 0, 0, "R3");
        exp_at(4, 0, 1, 0, 0, "R5");
        exp_at(7, 0, 1, 0, 0, "R5");
        tick(4);
        ls_below_th = 1'b0;
        tick(3);
        pwm_req = 1'b0;
        exp_at(2, 0, 1, 0, 0, "R8");
        tick(2);
        pwm_req = 1'b1;
        exp_at(1, 0, 0, 0, 0, "R5");
        tick(1);
        ls_below_th = 1'b1;
        exp_at(3, 0, 0, 0, 0, "R3");
        exp_at(4, 1, 0, 0, 0, "R5");
        tick(4);
        hs_below_th = 1'b0;

        // R6: force-low overrides the high-side request.
        force_low = 1'b1;
        exp_at(1, 0, 0, 0, 0, "R6");
        tick(1);
        hs_below_th = 1'b1;
        exp_at(4, 0, 1, 0, 0, "R6");
        tick(4);
        ls_below_th = 1'b0;
        exp_at(2, 0, 1, 0, 0, "R6");
        tick(2);

        // R7: tristate floats both sides even with requests present.
        tristate_req = 1'b1;
        force_low = 1'b0;
        exp_at(1, 0, 0, 1, 0, "R7");
        tick(1);
        ls_below_th = 1'b1;
        exp_at(3, 0, 0, 1, 0, "R7");
        exp_at(5, 0, 0, 1, 0, "R7");
        tick(5);
        tristate_req = 1'b0;
        // R2: flag already settled, so no further wait.
        exp_at(1, 1, 0, 0, 0, "R2");
        tick(1);
        hs_below_th = 1'b0;

        // R4: diode emulation during start-up.
        softstart_act = 1'b1;
        pwm_req = 1'b0;
        exp_at(1, 0, 0, 0, 0, "R11");
        tick(1);
        hs_below_th = 1'b1;
        exp_at(4, 0, 1, 0, 0, "R4");
        tick(4);
        ls_below_th = 1'b0;
        tick(1);
        phase_neg = 1'b1;
        exp_at(1, 0, 0, 0, 0, "R4");
        tick(1);
        phase_neg = 1'b0;
        ls_below_th = 1'b1;
        exp_at(3, 0, 0, 0, 0, "R4");
        exp_at(6, 0, 0, 0, 0, "R4");
        tick(6);
        pwm_req = 1'b1;
        exp_at(1, 1, 0, 0, 0, "R4");
        tick(1);
        hs_below_th = 1'b0;
        tick(2);
        pwm_req = 1'b0;
        exp_at(1, 0, 0, 0, 0, "R11");
        tick(1);
        hs_below_th = 1'b1;
        exp_at(4, 0, 1, 0, 0, "R4");
        tick(4);
        ls_below_th = 1'b0;

        // R8: after start-up, phase_neg leaves the low side on.
        softstart_act = 1'b0;
        phase_neg = 1'b1;
        exp_at(1, 0, 1, 0, 0, "R8");
        exp_at(4, 0, 1, 0, 0, "R8");
        tick(4);
        phase_neg = 1'b0;

        // R9: low-side flag stuck; watchdog releases after WD_LIMIT clocks.
        pwm_req = 1'b1;
        exp_at(1, 0, 0, 0, 0, "R9");
        exp_at(21, 0, 0, 0, 0, "R9");
        exp_at(22, 1, 0, 0, 1, "R9");
        exp_at(23, 1, 0, 0, 0, "R9");
        tick(23);
        hs_below_th = 1'b0;

        tick(3);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule